// File: doc/BRIEF.md
# Storage Sector Run Coalescer

This block turns a block index into a short series of multi-sector storage requests. A lookup first reads the block's starting byte offset from the index table of the selected disk slot. It then works out which 512-byte storage sectors the block spans. For each of those sectors it reads the physical sector number from the slot's sector map. Physically consecutive sectors are merged into one request. After each request the buffer address moves past the bytes that request covered.

The table memory sits outside the block and is reached through a word read port with a fixed latency of one cycle. The storage device sits behind a simple request and response pair, and only one request is outstanding at a time. The block holds four disk slots. A button press either inserts the disk or ejects it; an eject also moves to the next slot that holds an index table. When the lookup ends, the block reports whether the block is valid, how many sectors it spans and its byte offset inside the first sector, so a sequencer can locate the data in the buffer.

Top module: `sector_run_coalescer`

## Requirements
- R1: After reset, `busy`, `res_valid`, `sto_req_valid`, `mem_rd_en` and `disk_inserted` are 0, and `cur_slot` is 0.
- R2: A lookup reads the index entry at the slot's index base plus 4×index. Table words are big-endian: `mem_rd_data[7:0]` carries the byte at the lowest address, which is the most significant byte of the value.
- R3: If the slot's index base is all ones, or the index entry is all ones, the lookup ends with `res_ok`=0 and `res_count`=0, and no storage request is made.
- R4: For a start offset S and block length L=(sector size+1)×85, the block reports `res_offset` = S mod 512 and `res_count` = (S+L−1)/512 − S/512 + 1.
- R5: Map entry i (counting from 0) is read from the map base plus 4×(S/512 + i), for every sector the block spans, in ascending order.
- R6: Each maximal run of map entries in which every entry is one more than the one before becomes exactly one request: `sto_req_lba` is the run's first entry and `sto_req_count` is the run's length.
- R7: The first request carries `req_buf_addr` in `sto_req_buf`. Each later request carries the previous buffer address plus 512 × the previous run length.
- R8: Every request of a lookup carries the lookup's `req_write` on `sto_req_write`.
- R9: A request answered with `sto_err` ends the lookup at once with `res_ok`=0. No further request is made, and `res_count` still gives the spanned sector count. A lookup in which every request is answered with `sto_done` ends with `res_ok`=1.
- R10: Slot bases written through `cfg_we` keep only their low 29 bits. `cfg_clear` sets every base to all ones and `cur_slot` to 0.
- R11: A press while ejected sets `disk_inserted` and leaves `cur_slot` unchanged. A press while inserted clears `disk_inserted` and moves `cur_slot` to the next slot, in cyclic order, whose index base is not all ones. The current slot is the last one searched, and if no slot is populated `cur_slot` does not change.
- R12: `res_valid` is a pulse of one cycle, and `busy` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_clear | input | 1 | Empty all slots and select slot 0 |
| cfg_we | input | 1 | Write one slot's bases |
| cfg_slot | input | 2 | Slot written by cfg_we |
| cfg_index_base | input | 32 | Index table base for the slot |
| cfg_map_base | input | 32 | Sector map base for the slot |
| button | input | 1 | Insert/eject press, one cycle |
| disk_inserted | output | 1 | Disk is inserted |
| cur_slot | output | 2 | Selected disk slot |
| req_valid | input | 1 | Start a lookup (taken when not busy) |
| req_write | input | 1 | Lookup is for a write |
| req_index | input | 16 | Block index |
| req_sector_size | input | 8 | Sector size minus one, in bytes |
| req_buf_addr | input | 32 | Buffer address for the first request |
| busy | output | 1 | Lookup in progress |
| mem_rd_en | output | 1 | Table word read strobe |
| mem_rd_addr | output | 32 | Table byte address |
| mem_rd_data | input | 32 | Table word, one cycle after the strobe |
| sto_req_valid | output | 1 | Storage request outstanding |
| sto_req_write | output | 1 | Request direction |
| sto_req_lba | output | 32 | First physical sector |
| sto_req_count | output | 8 | Sectors in the request |
| sto_req_buf | output | 32 | Buffer address for the request |
| sto_done | input | 1 | Request completed |
| sto_err | input | 1 | Request failed |
| res_valid | output | 1 | Lookup result pulse |
| res_ok | output | 1 | Block is valid |
| res_count | output | 8 | Storage sectors spanned |
| res_offset | output | 9 | Byte offset inside the first sector |

## Verification
A table read returns its data one cycle after `mem_rd_en`, so each map entry costs two cycles. A request is answered in the cycle it appears, and the next request or the result follows one cycle after the response. The bench drives and samples only on falling edges. Its table memory registers the data on the rising edge after the strobe, which gives the stated latency without assuming how many cycles a lookup takes overall. The bench logs every table read and request as it appears, waits for the `res_valid` pulse, then compares the logs and the result with runs it computes itself from the table contents. It checks one falling edge later that the pulse has ended.

// File: rtl/src_pkg.sv
package src_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IDX_RD,
    ST_IDX_WT,
    ST_MAP_RD,
    ST_MAP_WT,
    ST_ISSUE,
    ST_DONE
  } eng_state_t;

  // Table words arrive with the lowest-address byte in bits 7:0.
  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Bytes in one block: (size field + 1) times the sectors per block.
  function automatic logic [WORD_W-1:0] block_bytes(input logic [7:0] sz, input int unsigned per_blk);
    return (WORD_W'(sz) + WORD_W'(1)) * WORD_W'(per_blk);
  endfunction

endpackage

// File: rtl/src_slot_bank.sv
module src_slot_bank #(
  parameter int NUM_SLOTS = 4,
  parameter int TBL_BITS  = 29,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clear,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [31:0]       cfg_index_base,
  input  logic [31:0]       cfg_map_base,
  input  logic              button,
  output logic              disk_inserted,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [31:0]       cur_index_base,
  output logic [31:0]       cur_map_base
);

  localparam logic [31:0] KEEP = {{(32-TBL_BITS){1'b0}}, {TBL_BITS{1'b1}}};

  logic [31:0]          ib_arr [NUM_SLOTS];
  logic [31:0]          mb_arr [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_ok;
  logic [SLOT_W-1:0]    cur_q;
  logic                 ins_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [31:0] ib_q, mb_q;
    always_ff @(posedge clk) begin
      if (!rst_n || cfg_clear) begin
        ib_q <= '1;
        mb_q <= '1;
      end else if (cfg_we && cfg_slot == SLOT_W'(g)) begin
        ib_q <= cfg_index_base & KEEP;
        mb_q <= cfg_map_base & KEEP;
      end
    end
    assign ib_arr[g]  = ib_q;
    assign mb_arr[g]  = mb_q;
    assign slot_ok[g] = (ib_q != '1);

    p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((ib_q == '1) || (ib_q[31:TBL_BITS] == '0)) && ((mb_q == '1) || (mb_q[31:TBL_BITS] == '0)))
      else $error("slot base not masked");
  end

  // Next populated slot after cur, searching cyclically; cur itself last.
  function automatic logic [SLOT_W-1:0] pick_next(input logic [SLOT_W-1:0] cur,
                                                  input logic [NUM_SLOTS-1:0] ok);
    logic [SLOT_W-1:0] r;
    logic found;
    r = cur;
    found = 1'b0;
    for (int k = 1; k <= NUM_SLOTS; k++) begin
      int c;
      c = (int'(cur) + k) % NUM_SLOTS;
      if (!found && ok[c]) begin
        r = SLOT_W'(c);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  logic eject_ev;
  assign eject_ev = button && ins_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      ins_q <= 1'b0;
    end else begin
      if (button) ins_q <= !ins_q;
      if (cfg_clear)     cur_q <= '0;
      else if (eject_ev) cur_q <= pick_next(cur_q, slot_ok);
    end
  end

  assign disk_inserted  = ins_q;
  assign cur_slot       = cur_q;
  assign cur_index_base = ib_arr[cur_q];
  assign cur_map_base   = mb_arr[cur_q];

  p_eject_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eject_ev |=> !ins_q) else $error("eject did not clear inserted");

  p_land_populated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eject_ev && (slot_ok != '0) && !cfg_clear && !cfg_we) |=> slot_ok[cur_q])
    else $error("eject landed on empty slot");

endmodule

// File: rtl/src_run_engine.sv
module src_run_engine #(
  parameter int IDX_W       = 16,
  parameter int CNT_W       = 8,
  parameter int SECT_SHIFT  = 9,
  parameter int BLK_SECTORS = 85
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [IDX_W-1:0]      req_index,
  input  logic [7:0]            req_sector_size,
  input  logic [31:0]           req_buf_addr,
  input  logic [31:0]           slot_index_base,
  input  logic [31:0]           slot_map_base,
  output logic                  busy,
  output logic                  mem_rd_en,
  output logic [31:0]           mem_rd_addr,
  input  logic [31:0]           mem_rd_data,
  output logic                  sto_req_valid,
  output logic                  sto_req_write,
  output logic [31:0]           sto_req_lba,
  output logic [CNT_W-1:0]      sto_req_count,
  output logic [31:0]           sto_req_buf,
  input  logic                  sto_done,
  input  logic                  sto_err,
  output logic                  res_valid,
  output logic                  res_ok,
  output logic [CNT_W-1:0]      res_count,
  output logic [SECT_SHIFT-1:0] res_offset
);
  import src_pkg::*;

  // Sectors touched by [start, start+len-1].
  function automatic logic [CNT_W-1:0] span_count(input logic [31:0] start, input logic [31:0] len);
    logic [32:0] last_b;
    last_b = {1'b0, start} + {1'b0, len} - 33'd1;
    return CNT_W'((last_b >> SECT_SHIFT) - ({1'b0, start} >> SECT_SHIFT) + 33'd1);
  endfunction

  eng_state_t            st_q;
  logic                  wr_q, ok_q, held_v_q;
  logic [IDX_W-1:0]      idx_q;
  logic [7:0]            size_q;
  logic [31:0]           ibase_q, mbase_q, buf_q, first_q, run_lba_q, held_q;
  logic [CNT_W-1:0]      cnt_q, rd_cnt_q, run_len_q;
  logic [SECT_SHIFT-1:0] off_q;

  logic [31:0] ent_w;
  logic        contig_w, last_rd_w;
  logic        run_break_ev, run_done_ev;

  assign ent_w        = swap_bytes(mem_rd_data);
  assign contig_w     = (ent_w == run_lba_q + 32'(run_len_q));
  assign last_rd_w    = ((rd_cnt_q + CNT_W'(1)) == cnt_q);
  assign run_break_ev = (st_q == ST_MAP_WT) && (rd_cnt_q != '0) && !contig_w;
  assign run_done_ev  = (st_q == ST_ISSUE) && sto_done && !sto_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      wr_q <= 1'b0; ok_q <= 1'b0; held_v_q <= 1'b0;
      idx_q <= '0; size_q <= '0;
      ibase_q <= '0; mbase_q <= '0; buf_q <= '0; first_q <= '0;
      run_lba_q <= '0; held_q <= '0;
      cnt_q <= '0; rd_cnt_q <= '0; run_len_q <= '0; off_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          wr_q     <= req_write;
          idx_q    <= req_index;
          size_q   <= req_sector_size;
          buf_q    <= req_buf_addr;
          ibase_q  <= slot_index_base;
          mbase_q  <= slot_map_base;
          ok_q     <= 1'b0;
          held_v_q <= 1'b0;
          cnt_q    <= '0;
          rd_cnt_q <= '0;
          off_q    <= '0;
          st_q     <= (slot_index_base == '1) ? ST_DONE : ST_IDX_RD;
        end
        ST_IDX_RD: st_q <= ST_IDX_WT;
        ST_IDX_WT: begin
          if (ent_w == '1) begin
            st_q <= ST_DONE;
          end else begin
            off_q   <= ent_w[SECT_SHIFT-1:0];
            first_q <= ent_w >> SECT_SHIFT;
            cnt_q   <= span_count(ent_w, block_bytes(size_q, BLK_SECTORS));
            st_q    <= ST_MAP_RD;
          end
        end
        ST_MAP_RD: st_q <= ST_MAP_WT;
        ST_MAP_WT: begin
          rd_cnt_q <= rd_cnt_q + CNT_W'(1);
          if (rd_cnt_q == '0 || contig_w) begin
            if (rd_cnt_q == '0) begin
              run_lba_q <= ent_w;
              run_len_q <= CNT_W'(1);
            end else begin
              run_len_q <= run_len_q + CNT_W'(1);
            end
            st_q <= last_rd_w ? ST_ISSUE : ST_MAP_RD;
          end else begin
            held_q   <= ent_w;
            held_v_q <= 1'b1;
            st_q     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (sto_err) begin
            ok_q <= 1'b0;
            st_q <= ST_DONE;
          end else if (sto_done) begin
            buf_q <= buf_q + (32'(run_len_q) << SECT_SHIFT);
            if (held_v_q) begin
              run_lba_q <= held_q;
              run_len_q <= CNT_W'(1);
              held_v_q  <= 1'b0;
              st_q      <= (rd_cnt_q == cnt_q) ? ST_ISSUE : ST_MAP_RD;
            end else begin
              ok_q <= 1'b1;
              st_q <= ST_DONE;
            end
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd_en   = 1'b0;
    mem_rd_addr = '0;
    if (st_q == ST_IDX_RD) begin
      mem_rd_en   = 1'b1;
      mem_rd_addr = ibase_q + (32'(idx_q) << 2);
    end else if (st_q == ST_MAP_RD) begin
      mem_rd_en   = 1'b1;
      mem_rd_addr = mbase_q + ((first_q + 32'(rd_cnt_q)) << 2);
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign sto_req_valid = (st_q == ST_ISSUE);
  assign sto_req_write = wr_q;
  assign sto_req_lba   = run_lba_q;
  assign sto_req_count = run_len_q;
  assign sto_req_buf   = buf_q;
  assign res_valid     = (st_q == ST_DONE);
  assign res_ok        = ok_q;
  assign res_count     = cnt_q;
  assign res_offset    = off_q;

  p_rd_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en) else $error("back-to-back table reads");

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sto_req_valid && !sto_done && !sto_err) |=>
      (sto_req_valid && $stable(sto_req_lba) && $stable(sto_req_count) && $stable(sto_req_buf)))
    else $error("request changed while waiting");

  p_break_issues_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_break_ev |=> sto_req_valid) else $error("run break without request");

  p_err_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sto_req_valid && sto_err) |=> (!sto_req_valid && res_valid && !res_ok))
    else $error("error did not abort");

  p_done_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_done_ev |=> !res_valid || res_ok) else $error("final success not valid");

  p_zero_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_count == '0) |-> !res_ok) else $error("zero count reported valid");

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!res_valid && !busy)) else $error("result not a pulse");

endmodule

// File: rtl/sector_run_coalescer.sv
module sector_run_coalescer #(
  parameter int NUM_SLOTS   = 4,
  parameter int TBL_BITS    = 29,
  parameter int IDX_W       = 16,
  parameter int CNT_W       = 8,
  parameter int SECT_SHIFT  = 9,
  parameter int BLK_SECTORS = 85,
  localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_clear,
  input  logic                  cfg_we,
  input  logic [SLOT_W-1:0]     cfg_slot,
  input  logic [31:0]           cfg_index_base,
  input  logic [31:0]           cfg_map_base,
  input  logic                  button,
  output logic                  disk_inserted,
  output logic [SLOT_W-1:0]     cur_slot,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [IDX_W-1:0]      req_index,
  input  logic [7:0]            req_sector_size,
  input  logic [31:0]           req_buf_addr,
  output logic                  busy,
  output logic                  mem_rd_en,
  output logic [31:0]           mem_rd_addr,
  input  logic [31:0]           mem_rd_data,
  output logic                  sto_req_valid,
  output logic                  sto_req_write,
  output logic [31:0]           sto_req_lba,
  output logic [CNT_W-1:0]      sto_req_count,
  output logic [31:0]           sto_req_buf,
  input  logic                  sto_done,
  input  logic                  sto_err,
  output logic                  res_valid,
  output logic                  res_ok,
  output logic [CNT_W-1:0]      res_count,
  output logic [SECT_SHIFT-1:0] res_offset
);

  logic [31:0] sel_ibase, sel_mbase;

  src_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .TBL_BITS(TBL_BITS)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .cfg_clear(cfg_clear), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_index_base(cfg_index_base), .cfg_map_base(cfg_map_base),
    .button(button), .disk_inserted(disk_inserted), .cur_slot(cur_slot),
    .cur_index_base(sel_ibase), .cur_map_base(sel_mbase)
  );

  src_run_engine #(.IDX_W(IDX_W), .CNT_W(CNT_W), .SECT_SHIFT(SECT_SHIFT),
                   .BLK_SECTORS(BLK_SECTORS)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_index(req_index),
    .req_sector_size(req_sector_size), .req_buf_addr(req_buf_addr),
    .slot_index_base(sel_ibase), .slot_map_base(sel_mbase),
    .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .sto_req_valid(sto_req_valid), .sto_req_write(sto_req_write), .sto_req_lba(sto_req_lba),
    .sto_req_count(sto_req_count), .sto_req_buf(sto_req_buf),
    .sto_done(sto_done), .sto_err(sto_err),
    .res_valid(res_valid), .res_ok(res_ok), .res_count(res_count), .res_offset(res_offset)
  );

endmodule

// File: tb/tb_sector_run_coalescer.sv
module tb_sector_run_coalescer;
  localparam int CLK_PERIOD = 10;
  localparam int NO_FAIL = 999;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, cfg_clear, cfg_we, button, req_valid, req_write;
  logic [1:0] cfg_slot, cur_slot;
  logic [31:0] cfg_index_base, cfg_map_base, req_buf_addr, mem_rd_addr, mem_rd_data;
  logic [31:0] sto_req_lba, sto_req_buf;
  logic [15:0] req_index;
  logic [7:0] req_sector_size, sto_req_count, res_count;
  logic [8:0] res_offset;
  logic disk_inserted, busy, mem_rd_en, sto_req_valid, sto_req_write, sto_done, sto_err;
  logic res_valid, res_ok;

  sector_run_coalescer dut (
    .clk(clk), .rst_n(rst_n), .cfg_clear(cfg_clear), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_index_base(cfg_index_base), .cfg_map_base(cfg_map_base), .button(button),
    .disk_inserted(disk_inserted), .cur_slot(cur_slot), .req_valid(req_valid),
    .req_write(req_write), .req_index(req_index), .req_sector_size(req_sector_size),
    .req_buf_addr(req_buf_addr), .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .sto_req_valid(sto_req_valid), .sto_req_write(sto_req_write),
    .sto_req_lba(sto_req_lba), .sto_req_count(sto_req_count), .sto_req_buf(sto_req_buf),
    .sto_done(sto_done), .sto_err(sto_err), .res_valid(res_valid), .res_ok(res_ok),
    .res_count(res_count), .res_offset(res_offset)
  );

  int nchk = 0, nfail = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Table memory: word array, data registered one cycle after the strobe.
  logic [31:0] mem [4096];
  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[13:2]];

  function automatic logic [31:0] to_lanes(input logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = v[8*(3-b) +: 8];
    return r;
  endfunction

  function automatic int unsigned start_of(input int i);
    return i * 1337 + (i % 3) * 511;
  endfunction

  function automatic int unsigned map_val(input int sel, input int k);
    if (sel == 1) return 7000 + k;
    if (k % 9 == 4) return 5000 + k * 10;
    return 2000 + k + (k / 6) * 2;
  endfunction

  // Logs filled while a lookup runs.
  int nreq = 0, nrd = 0, fail_at = NO_FAIL;
  logic [31:0] lg_lba [64], lg_buf [64], lg_rd [64];
  logic [7:0]  lg_cnt [64];
  logic        lg_wr [64];

  initial begin
    sto_done = 1'b0;
    sto_err  = 1'b0;
    forever begin
      @(negedge clk);
      sto_done = 1'b0;
      sto_err  = 1'b0;
      if (mem_rd_en && nrd < 64) begin
        lg_rd[nrd] = mem_rd_addr;
        nrd++;
      end
      if (sto_req_valid) begin
        if (nreq < 64) begin
          lg_lba[nreq] = sto_req_lba; lg_cnt[nreq] = sto_req_count;
          lg_buf[nreq] = sto_req_buf; lg_wr[nreq]  = sto_req_write;
        end
        if (nreq == fail_at) sto_err = 1'b1; else sto_done = 1'b1;
        nreq++;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  task automatic press;
    @(negedge clk); button = 1'b1;
    @(negedge clk); button = 1'b0;
  endtask

  task automatic load_slot(input logic [1:0] s, input logic [31:0] ib, input logic [31:0] mb);
    @(negedge clk); cfg_we = 1'b1; cfg_slot = s; cfg_index_base = ib; cfg_map_base = mb;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // absent_slot: the selected slot holds no index table.
  task automatic lookup(input int sel, input logic [31:0] mbase, input int idx, input int sz,
                        input logic [31:0] bufa, input bit wr, input int fail, input bit absent_slot);
    int unsigned st, len, first, last, n, off;
    int nr, exp_req;
    bit absent, exp_ok;
    logic [31:0] e_lba [64];
    int e_len [64];
    logic [31:0] bacc;
    int guard;
    absent = absent_slot || (idx >= 12);
    st = start_of(idx);
    len = (sz + 1) * 85;
    first = st / 512;
    last = (st + len - 1) / 512;
    n = absent ? 0 : last - first + 1;
    off = absent ? 0 : st % 512;
    nr = 0;
    for (int i = 0; i < int'(n); i++) begin
      int unsigned v;
      v = map_val(sel, int'(first) + i);
      if (nr > 0 && v == e_lba[nr-1] + e_len[nr-1]) e_len[nr-1]++;
      else begin e_lba[nr] = v; e_len[nr] = 1; nr++; end
    end
    exp_ok  = !absent && (fail >= nr);
    exp_req = absent ? 0 : ((fail >= nr) ? nr : fail + 1);

    nreq = 0; nrd = 0; fail_at = fail;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_index = 16'(idx);
    req_sector_size = 8'(sz); req_buf_addr = bufa;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!res_valid && guard < 3000) begin @(negedge clk); guard++; end
    chk("R12", "result arrived", {31'd0, res_valid}, 32'd1);
    chk(absent ? "R3" : "R9", "res_ok", {31'd0, res_ok}, {31'd0, exp_ok});
    chk("R4", "res_count", {24'd0, res_count}, n);
    chk("R4", "res_offset", {23'd0, res_offset}, off);
    chk(absent ? "R3" : "R6", "request count", nreq, exp_req);
    bacc = bufa;
    for (int r = 0; r < exp_req && r < nreq; r++) begin
      chk("R6", "run lba", lg_lba[r], e_lba[r]);
      chk("R6", "run length", {24'd0, lg_cnt[r]}, e_len[r]);
      chk("R7", "run buffer", lg_buf[r], bacc);
      chk("R8", "write flag", {31'd0, lg_wr[r]}, {31'd0, wr});
      bacc = bacc + 32'(e_len[r]) * 512;
    end
    if (absent_slot) begin
      chk("R3", "no table read", nrd, 0);
    end else begin
      chk("R2", "index address", lg_rd[0], 32'(idx * 4));
      if (exp_ok) begin
        chk("R5", "map read count", nrd, n + 1);
        for (int j = 1; j < nrd && j <= int'(n); j++)
          chk("R5", "map address", lg_rd[j], mbase + 32'((first + j - 1) * 4));
      end
    end
    @(negedge clk);
    chk("R12", "pulse ended", {30'd0, res_valid, busy}, 32'd0);
  endtask

  initial begin
    int szs [4] = '{0, 77, 231, 255};
    rst_n = 1'b0; cfg_clear = 1'b0; cfg_we = 1'b0; cfg_slot = '0;
    cfg_index_base = '0; cfg_map_base = '0; button = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_index = '0; req_sector_size = '0; req_buf_addr = '0;
    for (int w = 0; w < 4096; w++) mem[w] = '0;
    for (int i = 0; i < 16; i++) mem[i] = (i >= 12) ? 32'hFFFF_FFFF : to_lanes(start_of(i));
    for (int k = 0; k < 1024; k++) begin
      mem[32'h400 + k] = to_lanes(map_val(0, k));
      mem[32'hC00 + k] = to_lanes(map_val(1, k));
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", {31'd0, busy}, 0);
    chk("R1", "res_valid", {31'd0, res_valid}, 0);
    chk("R1", "sto_req_valid", {31'd0, sto_req_valid}, 0);
    chk("R1", "mem_rd_en", {31'd0, mem_rd_en}, 0);
    chk("R1", "inserted", {31'd0, disk_inserted}, 0);
    chk("R1", "cur_slot", {30'd0, cur_slot}, 0);

    // Slot 1 bases carry high garbage bits that must be dropped (R10).
    load_slot(2'd0, 32'h0000_0000, 32'h0000_1000);
    load_slot(2'd1, 32'hE000_0000, 32'hE000_3000);

    for (int sel = 0; sel < 2; sel++) begin
      for (int idx = 0; idx < 13; idx++) begin
        for (int s = 0; s < 4; s++) begin
          int f;
          f = (idx % 5 == 1) ? 0 : ((idx % 5 == 3) ? 1 : NO_FAIL);
          if (s != 1 && f != NO_FAIL) f = NO_FAIL;
          lookup(sel, sel ? 32'h3000 : 32'h1000, idx, szs[s],
                 32'h0100_0000 + 32'(idx * 64), bit'((idx + s) % 2), f, 1'b0);
        end
      end
      if (sel == 0) begin
        press;
        chk("R11", "insert keeps slot", {30'd0, cur_slot}, 0);
        chk("R11", "inserted", {31'd0, disk_inserted}, 1);
        press;
        chk("R11", "eject advances", {30'd0, cur_slot}, 1);
        chk("R11", "ejected", {31'd0, disk_inserted}, 0);
        chk("R10", "slot 1 selected for masked lookup", {30'd0, cur_slot}, 1);
      end
    end

    press; press;
    chk("R11", "cyclic wrap to slot 0", {30'd0, cur_slot}, 0);

    @(negedge clk); cfg_clear = 1'b1; @(negedge clk); cfg_clear = 1'b0;
    chk("R10", "clear selects slot 0", {30'd0, cur_slot}, 0);
    lookup(0, 32'h1000, 2, 10, 32'h10, 1'b0, NO_FAIL, 1'b1);

    press; press;
    chk("R11", "no populated slot keeps slot", {30'd0, cur_slot}, 0);
    load_slot(2'd3, 32'h0, 32'h1000);
    press; press;
    chk("R11", "advance to only slot 3", {30'd0, cur_slot}, 3);
    press; press;
    chk("R11", "single slot returns to itself", {30'd0, cur_slot}, 3);
    lookup(0, 32'h1000, 5, 40, 32'h2000, 1'b1, NO_FAIL, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule